// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting channel for a multi-channel interval timer. A host-side register interface sets an operating mode, loads an initial count and drives a gate level. A separate count-enable strobe paces the counting. The channel produces a mode-dependent output waveform, a live count value for the register interface to read back, and a one-cycle terminal pulse that downstream interrupt logic can consume.

Six operating modes are supported. In the interrupt-on-terminal mode the output stays high once the count is reached. In the retriggerable one-shot mode the output is high until the count is reached. The rate-generator mode gives a periodic pulse. The square-wave mode gives a roughly half-duty wave and its visible count falls by two per step. Two strobe modes give a single high step at the count, one triggered by software and one by the gate. Mode codes 6 and 7 are aliases of 2 and 3. A loaded value of zero stands for the full range of 2^W. Byte sequencing on the host bus, BCD counting and interrupt routing are handled by neighbouring logic.

Top module: `interval_chan`

## Requirements
- R1: After reset the channel is idle. `out_level` is 0, `term_pulse` is 0 and `count_out` is 0, because the held count is 2^W. Count strobes have no effect until a mode is written with `cfg_wr`.
- R2: A `load_wr` of value 0 is taken as 2^W. `count_out` reads 0 on the next clock, and reads 0xFFFF after one advance in mode 0.
- R3: A `load_wr` restarts the channel on the next clock, even in the middle of a count. The elapsed step count is cleared and `count_out` shows the new value, truncated to W bits.
- R4: In mode 0, `out_level` stays low while elapsed < N. It goes high when elapsed reaches N and stays high. `count_out` is (N − elapsed) mod 2^W and keeps wrapping. `term_pulse` is high for exactly one clock when elapsed reaches N.
- R5: In modes 0 and 4, a low gate blocks advances. A rising gate edge does not restart the count.
- R6: In modes 1, 2, 3 and 5, a rising gate edge restarts counting from the loaded N. The gate level does not block advances.
- R7: In mode 1, `out_level` is high while elapsed < N and low afterwards. `count_out` is (N − elapsed) mod 2^W.
- R8: In mode 2, `count_out` is N − (elapsed mod N). `out_level` is high while elapsed is a nonzero multiple of N. `term_pulse` fires for one clock each time a period completes.
- R9: In mode 3, `count_out` is N − ((2·elapsed) mod N). `out_level` is high while (elapsed mod N) < (N+1)/2.
- R10: In modes 4 and 5, `out_level` is high only while elapsed equals N. `term_pulse` fires once at that point.
- R11: One advance happens per rising edge of `tick`. Holding `tick` high gives exactly one advance.
- R12: `cfg_mode` codes 6 and 7 behave exactly as modes 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count-enable strobe; each rising edge is one advance |
| gate | input | 1 | Gate level |
| cfg_wr | input | 1 | Mode write strobe |
| cfg_mode | input | 3 | Operating mode code 0–7 |
| load_wr | input | 1 | Count load strobe (count bytes complete) |
| load_val | input | W | Initial count; 0 means 2^W |
| out_level | output | 1 | Channel output waveform |
| count_out | output | W | Live current count for read-back |
| term_pulse | output | 1 | One-clock pulse at terminal count or period end |

## Verification
The hardest situations to reach are the far edges of the wrapping arithmetic. One is the full-range count that comes from loading zero. Another is the square-wave mode with an odd count, where the doubled phase wraps partway through a period and the output goes low before the period boundary. The directed tasks load small odd and even counts and step the strobe one edge at a time, so each period boundary is checked. A zero load is followed by a single advance to observe the wrap to 0xFFFF. Gate edges are driven between advances, so a restart and a blocked advance can each be told apart from a normal step.

// File: rtl/ict_pkg.sv
package ict_pkg;

  typedef enum logic [2:0] {
    M_TERM     = 3'd0,
    M_ONESHOT  = 3'd1,
    M_RATE     = 3'd2,
    M_SQUARE   = 3'd3,
    M_SWSTROBE = 3'd4,
    M_HWSTROBE = 3'd5
  } chan_mode_e;

  typedef enum logic [1:0] {
    ST_BEFORE = 2'd0,
    ST_AT     = 2'd1,
    ST_PAST   = 2'd2
  } os_stage_e;

  // codes 6 and 7 fold onto the rate and square modes
  function automatic chan_mode_e fold_mode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return chan_mode_e'({1'b0, code[1:0]});
    return chan_mode_e'(code);
  endfunction

endpackage

// File: rtl/ict_oneshot.sv
module ict_oneshot #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic                adv,
  input  logic [W:0]          n_val,
  output logic [W-1:0]        remain,
  output ict_pkg::os_stage_e  stage,
  output logic                hit
);
  import ict_pkg::*;

  logic [W-1:0] dn_q;
  os_stage_e    st_q;

  assign hit    = adv && !restart && (st_q == ST_BEFORE) && (dn_q == W'(1));
  assign remain = dn_q;
  assign stage  = st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_q <= '0;
      st_q <= ST_BEFORE;
    end else if (restart) begin
      dn_q <= n_val[W-1:0];
      st_q <= ST_BEFORE;
    end else if (adv) begin
      dn_q <= dn_q - W'(1);
      case (st_q)
        ST_BEFORE: if (dn_q == W'(1)) st_q <= ST_AT;
        ST_AT:     st_q <= ST_PAST;
        default:   st_q <= ST_PAST;
      endcase
    end
  end

  // R11
  dn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!restart && !adv) |=> $stable(dn_q));

endmodule

// File: rtl/ict_phase.sv
module ict_phase #(
  parameter int W    = 16,
  parameter int STEP = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       adv,
  input  logic [W:0] n_val,
  output logic [W:0] phase,
  output logic       wrap
);
  localparam int PW = W + 2;

  logic [W:0]    ph_q;
  logic [PW-1:0] nx;

  always_comb begin
    nx = PW'(ph_q) + PW'(STEP);
    for (int i = 0; i < STEP; i++) begin
      if (nx >= PW'(n_val)) nx = nx - PW'(n_val);
    end
  end

  assign wrap  = adv && !restart && (nx == '0);
  assign phase = ph_q;

  always_ff @(posedge clk) begin
    if (rst || restart) ph_q <= '0;
    else if (adv)       ph_q <= nx[W:0];
  end

  // R8
  phase_range_chk: assert property (@(posedge clk) disable iff (rst)
    ph_q < n_val);

endmodule

// File: rtl/interval_chan.sv
module interval_chan #(
  parameter int   W          = 16,
  parameter logic GATE_RESET = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         gate,
  input  logic         cfg_wr,
  input  logic [2:0]   cfg_mode,
  input  logic         load_wr,
  input  logic [W-1:0] load_val,
  output logic         out_level,
  output logic [W-1:0] count_out,
  output logic         term_pulse
);
  import ict_pkg::*;

  localparam int         NW   = W + 1;
  localparam logic [W:0] FULL = NW'(1) << W;

  logic          tick_q, gate_q, valid_q, started_q, term_q;
  chan_mode_e    mode_q;
  logic [W:0]    n_q, load_n;
  logic          gate_mode, restart, adv;
  logic [W-1:0]  os_remain;
  os_stage_e     os_stage;
  logic          os_hit;
  logic [W:0]    ph1, ph2;
  logic          wrap1, wrap2;
  logic [W+1:0]  half;
  logic          term_d;

  assign load_n    = (load_val == '0) ? FULL : {1'b0, load_val};
  assign gate_mode = (mode_q == M_TERM) || (mode_q == M_SWSTROBE);
  assign restart   = load_wr || (valid_q && !gate_mode && gate && !gate_q);
  assign adv       = valid_q && tick && !tick_q && (!gate_mode || gate);
  assign half      = ({1'b0, n_q} + (W+2)'(1)) >> 1;

  ict_oneshot #(.W(W)) u_os (
    .clk(clk), .rst(rst), .restart(restart), .adv(adv), .n_val(load_wr ? load_n : n_q),
    .remain(os_remain), .stage(os_stage), .hit(os_hit)
  );

  ict_phase #(.W(W), .STEP(1)) u_ph1 (
    .clk(clk), .rst(rst), .restart(restart), .adv(adv), .n_val(n_q),
    .phase(ph1), .wrap(wrap1)
  );

  ict_phase #(.W(W), .STEP(2)) u_ph2 (
    .clk(clk), .rst(rst), .restart(restart), .adv(adv), .n_val(n_q),
    .phase(ph2), .wrap(wrap2)
  );

  always_comb begin
    case (mode_q)
      M_RATE, M_SQUARE: term_d = wrap1;
      default:          term_d = os_hit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q    <= 1'b0;
      gate_q    <= GATE_RESET;
      valid_q   <= 1'b0;
      mode_q    <= M_TERM;
      n_q       <= FULL;
      started_q <= 1'b0;
      term_q    <= 1'b0;
    end else begin
      tick_q <= tick;
      gate_q <= gate;
      if (cfg_wr) begin
        valid_q <= 1'b1;
        mode_q  <= fold_mode(cfg_mode);
      end
      if (load_wr) n_q <= load_n;
      if (restart)  started_q <= 1'b0;
      else if (adv) started_q <= 1'b1;
      term_q <= valid_q && term_d;
    end
  end

  always_comb begin
    out_level = 1'b0;
    count_out = os_remain;
    if (valid_q) begin
      case (mode_q)
        M_TERM:    out_level = (os_stage != ST_BEFORE);
        M_ONESHOT: out_level = (os_stage == ST_BEFORE);
        M_RATE: begin
          out_level = started_q && (ph1 == '0);
          count_out = W'(n_q - ph1);
        end
        M_SQUARE: begin
          out_level = ((W+2)'(ph1) < half);
          count_out = W'(n_q - ph2);
        end
        default:   out_level = (os_stage == ST_AT);
      endcase
    end
  end

  assign term_pulse = term_q;

  // R4
  term_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && mode_q == M_TERM && out_level && !load_wr && !cfg_wr) |=> out_level);

  // R4
  term_single_chk: assert property (@(posedge clk) disable iff (rst)
    term_pulse |=> !term_pulse);

  // R5
  gate_block_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && gate_mode && !gate && !load_wr && !cfg_wr) |=> $stable(count_out));

endmodule

// File: tb/interval_chan_test.sv
module interval_chan_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst, tick, gate, cfg_wr, load_wr;
  logic [2:0]   cfg_mode;
  logic [W-1:0] load_val;
  logic         out_level, term_pulse;
  logic [W-1:0] count_out;

  int checks = 0;
  int failures = 0;
  bit timed_out = 0;

  always #2.5 clk = ~clk;

  interval_chan #(.W(W), .GATE_RESET(1'b1)) uut (
    .clk(clk), .rst(rst), .tick(tick), .gate(gate), .cfg_wr(cfg_wr),
    .cfg_mode(cfg_mode), .load_wr(load_wr), .load_val(load_val),
    .out_level(out_level), .count_out(count_out), .term_pulse(term_pulse)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic setup(input logic [2:0] m, input logic [W-1:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_mode = m;
    @(negedge clk); cfg_wr = 1'b0; load_wr = 1'b1; load_val = v;
    @(negedge clk); load_wr = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 out", out_level, 0);
    check("R1 term", term_pulse, 0);
    check("R1 count", count_out, 0);
    steps(2);
    check("R1 idle count", count_out, 0);
    check("R1 idle out", out_level, 0);
  endtask

  task automatic t_mode0();
    setup(3'd0, 16'd5);
    check("R4 load", count_out, 5);
    check("R4 low", out_level, 0);
    steps(4);
    check("R4 count4", count_out, 1);
    check("R4 still low", out_level, 0);
    step();
    check("R4 reach out", out_level, 1);
    check("R4 term", term_pulse, 1);
    check("R4 zero", count_out, 0);
    @(negedge clk);
    check("R4 term one clk", term_pulse, 0);
    step();
    check("R4 wrap", count_out, 16'hFFFF);
    check("R4 sticky", out_level, 1);
  endtask

  task automatic t_hold();
    setup(3'd0, 16'd9);
    @(negedge clk); tick = 1'b1;
    repeat (5) @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
    check("R11 held tick", count_out, 8);
  endtask

  task automatic t_gate04();
    setup(3'd0, 16'd10);
    gate = 1'b0;
    steps(3);
    check("R5 inhibited", count_out, 10);
    gate = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 no restart", count_out, 10);
    step();
    check("R5 counts", count_out, 9);
    setup(3'd4, 16'd6);
    step();
    gate = 1'b0;
    steps(2);
    gate = 1'b1;
    repeat (2) @(negedge clk);
    check("R5 mode4", count_out, 5);
  endtask

  task automatic t_zero();
    setup(3'd0, 16'd0);
    check("R2 load zero", count_out, 0);
    step();
    check("R2 wrap", count_out, 16'hFFFF);
    check("R2 out", out_level, 0);
  endtask

  task automatic t_mode1();
    setup(3'd1, 16'd3);
    check("R7 high", out_level, 1);
    steps(3);
    check("R7 low", out_level, 0);
    check("R7 count", count_out, 0);
    gate = 1'b0;
    @(negedge clk); gate = 1'b1;
    @(negedge clk);
    check("R6 retrigger count", count_out, 3);
    check("R6 retrigger out", out_level, 1);
    gate = 1'b0;
    step();
    check("R6 gate low counts", count_out, 2);
    gate = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_mode2(input logic [2:0] code, input string req);
    setup(code, 16'd4);
    check({req, " load"}, count_out, 4);
    check({req, " out0"}, out_level, 0);
    steps(3);
    check({req, " c1"}, count_out, 1);
    step();
    check({req, " pulse"}, out_level, 1);
    check({req, " term"}, term_pulse, 1);
    check({req, " reload"}, count_out, 4);
    step();
    check({req, " after"}, out_level, 0);
    check({req, " c3"}, count_out, 3);
  endtask

  task automatic t_gate2();
    setup(3'd2, 16'd4);
    steps(2);
    check("R6 mode2 mid", count_out, 2);
    gate = 1'b0;
    @(negedge clk); gate = 1'b1;
    @(negedge clk);
    check("R6 mode2 restart", count_out, 4);
  endtask

  task automatic t_reload();
    setup(3'd2, 16'd4);
    steps(2);
    @(negedge clk); load_wr = 1'b1; load_val = 16'd7;
    @(negedge clk); load_wr = 1'b0;
    check("R3 reload", count_out, 7);
    step();
    check("R3 fresh", count_out, 6);
  endtask

  task automatic t_mode3(input logic [2:0] code, input string req);
    logic [15:0] ec [6] = '{5, 3, 1, 4, 2, 5};
    logic        eo [6] = '{1, 1, 1, 0, 0, 1};
    setup(code, 16'd5);
    for (int i = 0; i < 6; i++) begin
      if (i > 0) step();
      check({req, " count"}, count_out, ec[i]);
      check({req, " out"}, out_level, eo[i]);
    end
  endtask

  task automatic t_strobe();
    setup(3'd4, 16'd2);
    step();
    check("R10 before", out_level, 0);
    step();
    check("R10 at", out_level, 1);
    check("R10 term", term_pulse, 1);
    step();
    check("R10 past", out_level, 0);
    setup(3'd5, 16'd1);
    steps(2);
    check("R10 m5 past", out_level, 0);
    gate = 1'b0;
    @(negedge clk); gate = 1'b1;
    @(negedge clk);
    step();
    check("R10 m5 retrig", out_level, 1);
  endtask

  task automatic run_all();
    t_reset();
    t_mode0();
    t_hold();
    t_gate04();
    t_zero();
    t_mode1();
    t_mode2(3'd2, "R8");
    t_mode2(3'd6, "R12");
    t_gate2();
    t_reload();
    t_mode3(3'd3, "R9");
    t_mode3(3'd7, "R12 sq");
    t_strobe();
  endtask

  initial begin
    rst = 1'b1; tick = 1'b0; gate = 1'b1; cfg_wr = 1'b0; load_wr = 1'b0;
    cfg_mode = '0; load_val = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=expired expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule